// File: doc/BRIEF.md
# Debug Breakpoint Response Controller

This block sits between the breakpoint comparators and the processor core. It turns trigger events into the response chosen by a 2-bit response field. That response is a core halt, a debug interrupt, or no action. In every case it keeps a sticky record of which breakpoint level fired.

The two kinds of trigger are timed differently. A program-counter match is taken at the instruction-boundary sample pulse it arrives with, so it acts before the matched instruction runs. An address or data match is latched and waits for a later sample pulse.

A debug interrupt:
- outranks every normal interrupt level, including the nonmaskable level 7;
- shows a dedicated status code for a fixed number of cycles;
- places the core in emulator mode, where interrupts are masked until an exception-return completion pulse arrives.

Top module: `dbg_bkpt_resp`

## Requirements
- R1: On `tdr_wr` the response field loads from `tdr_wdata`. Value 2'b01 selects halt and 2'b10 selects debug interrupt. Values 2'b00 and 2'b11 request nothing, although status bits are still recorded. After reset the field is 2'b00.
- R2: In halt mode a recognized trigger sets `halt_req` at the next edge. `halt_req` stays set until `tdr_wr`, and while it is set `pst` shows 4'hF.
- R3: In debug-interrupt mode a recognized trigger raises `dbg_irq_req` for exactly one cycle, with `dbg_vector` equal to 12. `emu_mode` is set at the same edge.
- R4: After a debug-interrupt recognition, `pst` shows 4'hD for exactly 4 cycles. It then returns to `core_status`, unless a halt is in effect.
- R5: A `pc_hit` is recognized at the `sample_pt` cycle it accompanies. An `ad_hit` is latched and is recognized only at a later `sample_pt` cycle, never at the one it arrives with.
- R6: In a cycle where a debug interrupt is recognized, `fwd_irq_level` is 0, even when `irq_level` is 7.
- R7: While `emu_mode` is set, `fwd_irq_level` is 0 and no new trigger is recognized. A `rte_done` pulse clears `emu_mode` at the next edge.
- R8: A PC trigger that is still asserted when emulator mode ends produces a new debug interrupt at the next sample pulse.
- R9: `bstat[1]` records level-2 hits and `bstat[0]` records level-1 hits. `hit_l2` selects the level of a `pc_hit` or `ad_hit`, and recording happens in every response mode.
- R10: `csr_rd` clears `bstat` when `bstat[1]` is set, or when `bstat[0]` is set and `lvl2_armed` is 0. Otherwise the read leaves `bstat` unchanged.
- R11: `tdr_wr` clears `bstat`, every latched trigger and `halt_req`, and no trigger is recognized in that cycle.
- R12: After reset `halt_req`, `dbg_irq_req`, `emu_mode` and `bstat` are 0. `pst` follows `core_status`, and `fwd_irq_level` follows `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_hit | input | 1 | Program-counter comparator match |
| ad_hit | input | 1 | Address/data comparator match |
| hit_l2 | input | 1 | Current hit belongs to level 2 (else level 1) |
| lvl2_armed | input | 1 | Level-2 breakpoint enabled |
| sample_pt | input | 1 | Once-per-instruction interrupt sample pulse |
| irq_level | input | 3 | Incoming interrupt level |
| rte_done | input | 1 | Exception return completed |
| csr_rd | input | 1 | Status register read strobe |
| tdr_wr | input | 1 | Trigger-definition write strobe |
| tdr_wdata | input | 2 | Response field write value |
| core_status | input | 4 | Normal processor-status code from the core |
| halt_req | output | 1 | Core halt request |
| dbg_irq_req | output | 1 | Debug interrupt request pulse |
| dbg_vector | output | 8 | Exception vector number for the debug interrupt |
| pst | output | 4 | Processor-status code shown externally |
| emu_mode | output | 1 | Emulator mode active |
| fwd_irq_level | output | 3 | Interrupt level passed on to the core |
| bstat | output | 2 | Sticky breakpoint status {level2, level1} |

## Verification
The response logic is driven with several trigger patterns, and each one separates a different pair of behaviours. An address/data hit that coincides with a sample pulse tells deferred recognition apart from immediate recognition. A PC hit on a sample pulse checks that recognition comes without delay. A PC hit held high across an exception return confirms re-triggering. A level-7 request during recognition and during emulator mode shows the priority and the masking. Status reads are tried with only level 1 set, with level 2 armed and not armed, and with level 2 set, which separates the clear conditions. The halt and no-action encodings are then tried against the same triggers.

// File: rtl/dbg_bkpt_resp.sv
module dbg_bkpt_resp #(
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned PST_W       = 4,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned SHOW_CYCLES = 4,
  parameter int unsigned DBG_VEC     = 12,
  parameter logic [PST_W-1:0] PST_HALT = 4'hF,
  parameter logic [PST_W-1:0] PST_DBG  = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_hit,
  input  logic             ad_hit,
  input  logic             hit_l2,
  input  logic             lvl2_armed,
  input  logic             sample_pt,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             rte_done,
  input  logic             csr_rd,
  input  logic             tdr_wr,
  input  logic [1:0]       tdr_wdata,
  input  logic [PST_W-1:0] core_status,
  output logic             halt_req,
  output logic             dbg_irq_req,
  output logic [VEC_W-1:0] dbg_vector,
  output logic [PST_W-1:0] pst,
  output logic             emu_mode,
  output logic [LVL_W-1:0] fwd_irq_level,
  output logic [1:0]       bstat
);
  localparam int unsigned CNT_W = $clog2(SHOW_CYCLES + 1);
  localparam logic [1:0] RSP_HALT = 2'b01;
  localparam logic [1:0] RSP_DINT = 2'b10;

  logic [1:0]       rsp;
  logic             pc_pend, ad_pend;
  logic [CNT_W-1:0] show_cnt;

  wire armed  = (rsp == RSP_HALT) || (rsp == RSP_DINT);
  wire any_hit = pc_hit | ad_hit;
  wire take   = sample_pt && !emu_mode && !halt_req && !tdr_wr && armed
                && (pc_pend || pc_hit || ad_pend);
  wire take_dint = take && (rsp == RSP_DINT);
  wire take_halt = take && (rsp == RSP_HALT);
  wire stat_clr  = csr_rd && (bstat[1] || (bstat[0] && !lvl2_armed));

  assign dbg_vector    = VEC_W'(DBG_VEC);
  assign fwd_irq_level = (emu_mode || take_dint) ? '0 : irq_level;
  assign pst = halt_req        ? PST_HALT :
               (show_cnt != 0) ? PST_DBG  : core_status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp <= 2'b00;
    end else if (tdr_wr) begin
      rsp <= tdr_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_pend <= 1'b0;
      ad_pend <= 1'b0;
    end else if (tdr_wr) begin
      pc_pend <= 1'b0;
      ad_pend <= 1'b0;
    end else if (take) begin
      pc_pend <= 1'b0;
      ad_pend <= ad_hit && armed;
    end else begin
      pc_pend <= pc_pend || (pc_hit && armed);
      ad_pend <= ad_pend || (ad_hit && armed);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
    end else if (tdr_wr) begin
      halt_req <= 1'b0;
    end else if (take_halt) begin
      halt_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_irq_req <= 1'b0;
      emu_mode    <= 1'b0;
      show_cnt    <= '0;
    end else begin
      dbg_irq_req <= take_dint;
      if (take_dint) begin
        emu_mode <= 1'b1;
        show_cnt <= CNT_W'(SHOW_CYCLES);
      end else begin
        if (rte_done) emu_mode <= 1'b0;
        if (show_cnt != 0) show_cnt <= show_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bstat <= 2'b00;
    end else if (tdr_wr) begin
      bstat <= 2'b00;
    end else begin
      bstat <= (stat_clr ? 2'b00 : bstat)
               | {any_hit && hit_l2, any_hit && !hit_l2};
    end
  end
endmodule

// File: rtl/dbg_bkpt_resp_chk.sv
module dbg_bkpt_resp_chk #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned PST_W = 4,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc_hit,
  input logic             ad_hit,
  input logic             csr_rd,
  input logic             tdr_wr,
  input logic             rte_done,
  input logic             halt_req,
  input logic             dbg_irq_req,
  input logic [VEC_W-1:0] dbg_vector,
  input logic [PST_W-1:0] pst,
  input logic             emu_mode,
  input logic [LVL_W-1:0] fwd_irq_level,
  input logic [1:0]       bstat
);
  AST_REQ_SETS_EMU: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_req |-> (emu_mode && dbg_vector == VEC_W'(12))); // R3
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_req |=> !dbg_irq_req); // R3
  AST_EMU_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> (fwd_irq_level == '0)); // R7
  AST_EMU_ENTRY_PST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(emu_mode) && !halt_req) |-> (pst == PST_W'(4'hD))); // R4
  AST_HALT_PST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> (pst == PST_W'(4'hF))); // R2
  AST_RTE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && rte_done && !dbg_irq_req) |=> !emu_mode); // R7
  AST_DEF_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_wr |=> (bstat == 2'b00 && !halt_req && !dbg_irq_req)); // R11
  AST_L2_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && bstat[1] && !pc_hit && !ad_hit) |=> (bstat == 2'b00)); // R10
endmodule

bind dbg_bkpt_resp dbg_bkpt_resp_chk #(.LVL_W(LVL_W), .PST_W(PST_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_dbg_bkpt_resp.sv
`timescale 1ns/1ps
module sim_dbg_bkpt_resp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_hit = 0, ad_hit = 0, hit_l2 = 0, lvl2_armed = 0, sample_pt = 0;
  logic [2:0] irq_level = 0;
  logic rte_done = 0, csr_rd = 0, tdr_wr = 0;
  logic [1:0] tdr_wdata = 0;
  logic [3:0] core_status = 4'h3;
  logic halt_req, dbg_irq_req, emu_mode;
  logic [7:0] dbg_vector;
  logic [3:0] pst;
  logic [2:0] fwd_irq_level;
  logic [1:0] bstat;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    string tag;
    logic [3:0] pst;
    logic halt, req, emu;
    logic [1:0] bs;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  dbg_bkpt_resp u0 (
    .clk(clk), .rst_n(rst_n), .pc_hit(pc_hit), .ad_hit(ad_hit), .hit_l2(hit_l2),
    .lvl2_armed(lvl2_armed), .sample_pt(sample_pt), .irq_level(irq_level),
    .rte_done(rte_done), .csr_rd(csr_rd), .tdr_wr(tdr_wr), .tdr_wdata(tdr_wdata),
    .core_status(core_status), .halt_req(halt_req), .dbg_irq_req(dbg_irq_req),
    .dbg_vector(dbg_vector), .pst(pst), .emu_mode(emu_mode),
    .fwd_irq_level(fwd_irq_level), .bstat(bstat));

  task automatic tick(string tag, logic [3:0] e_pst, logic e_halt, logic e_req,
                      logic e_emu, logic [1:0] e_bs);
    exp_t e;
    @(posedge clk);
    #1;
    e.tag = tag; e.pst = e_pst; e.halt = e_halt; e.req = e_req; e.emu = e_emu; e.bs = e_bs;
    q.push_back(e);
    pc_hit = 0; ad_hit = 0; sample_pt = 0; rte_done = 0; csr_rd = 0; tdr_wr = 0;
  endtask

  task automatic chk_fwd(string tag, logic [2:0] exp_lvl);
    #2;
    checks++;
    if (fwd_irq_level !== exp_lvl) begin
      failures++;
      $display("FAIL %s fwd_irq_level actual=%0d expected=%0d", tag, fwd_irq_level, exp_lvl);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pst !== e.pst || halt_req !== e.halt || dbg_irq_req !== e.req ||
          emu_mode !== e.emu || bstat !== e.bs ||
          (dbg_irq_req === 1'b1 && dbg_vector !== 8'd12)) begin
        failures++;
        $display("FAIL %s actual pst=%h halt=%b req=%b emu=%b bstat=%b vec=%0d expected pst=%h halt=%b req=%b emu=%b bstat=%b vec=12",
                 e.tag, pst, halt_req, dbg_irq_req, emu_mode, bstat, dbg_vector,
                 e.pst, e.halt, e.req, e.emu, e.bs);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    irq_level = 3'd2;
    chk_fwd("R12", 3'd2);
    tick("R12 reset state", 4'h3, 0, 0, 0, 2'b00);

    tdr_wr = 1; tdr_wdata = 2'b10;
    tick("R1 select debug interrupt", 4'h3, 0, 0, 0, 2'b00);
    ad_hit = 1; sample_pt = 1; hit_l2 = 0;
    tick("R5 ad hit waits", 4'h3, 0, 0, 0, 2'b01);
    tick("R5 ad idle", 4'h3, 0, 0, 0, 2'b01);
    sample_pt = 1; irq_level = 3'd7;
    chk_fwd("R6 level7 outranked", 3'd0);
    tick("R3 debug interrupt", 4'hD, 0, 1, 1, 2'b01);
    chk_fwd("R7 masked in emu", 3'd0);
    tick("R4 pst D 2", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 pst D 3", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 pst D 4", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 pst restored", 4'h3, 0, 0, 1, 2'b01);
    sample_pt = 1;
    tick("R7 no recognition in emu", 4'h3, 0, 0, 1, 2'b01);
    rte_done = 1;
    tick("R7 rte exits", 4'h3, 0, 0, 0, 2'b01);
    chk_fwd("R7 unmasked", 3'd7);
    irq_level = 3'd2;
    csr_rd = 1; lvl2_armed = 0;
    tick("R10 l1 read clears", 4'h3, 0, 0, 0, 2'b00);

    pc_hit = 1; sample_pt = 1;
    tick("R5 pc hit immediate", 4'hD, 0, 1, 1, 2'b01);
    tick("R4 b2", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 b3", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 b4", 4'hD, 0, 0, 1, 2'b01);
    tick("R4 b5", 4'h3, 0, 0, 1, 2'b01);
    rte_done = 1; pc_hit = 1;
    tick("R8 rte with trigger armed", 4'h3, 0, 0, 0, 2'b01);
    pc_hit = 1; sample_pt = 1;
    tick("R8 retrigger", 4'hD, 0, 1, 1, 2'b01);
    rte_done = 1;
    tick("R4 early rte", 4'hD, 0, 0, 0, 2'b01);
    tick("R4 c3", 4'hD, 0, 0, 0, 2'b01);
    tick("R4 c4", 4'hD, 0, 0, 0, 2'b01);
    tick("R4 c5", 4'h3, 0, 0, 0, 2'b01);

    csr_rd = 1; lvl2_armed = 1;
    tick("R10 l1 read kept when l2 armed", 4'h3, 0, 0, 0, 2'b01);
    ad_hit = 1; hit_l2 = 1;
    tick("R9 level2 recorded", 4'h3, 0, 0, 0, 2'b11);
    hit_l2 = 0;
    csr_rd = 1;
    tick("R10 l2 read clears", 4'h3, 0, 0, 0, 2'b00);
    tdr_wr = 1; tdr_wdata = 2'b01;
    tick("R11 write drops pending", 4'h3, 0, 0, 0, 2'b00);
    sample_pt = 1;
    tick("R11 no stale recognition", 4'h3, 0, 0, 0, 2'b00);

    ad_hit = 1;
    tick("R2 ad latched", 4'h3, 0, 0, 0, 2'b01);
    sample_pt = 1;
    tick("R2 halt", 4'hF, 1, 0, 0, 2'b01);
    pc_hit = 1; sample_pt = 1; irq_level = 3'd5;
    chk_fwd("R2 no debug irq in halt mode", 3'd5);
    tick("R2 halt held", 4'hF, 1, 0, 0, 2'b01);
    tdr_wr = 1; tdr_wdata = 2'b00; pc_hit = 1;
    tick("R11 write clears halt and status", 4'h3, 0, 0, 0, 2'b00);

    pc_hit = 1; sample_pt = 1;
    tick("R1 mode 00 no action", 4'h3, 0, 0, 0, 2'b01);
    tdr_wr = 1; tdr_wdata = 2'b11;
    tick("R1 select 11", 4'h3, 0, 0, 0, 2'b00);
    ad_hit = 1; hit_l2 = 1; sample_pt = 1;
    tick("R1 mode 11 no action", 4'h3, 0, 0, 0, 2'b10);
    hit_l2 = 0; sample_pt = 1;
    tick("R1 mode 11 stays idle", 4'h3, 0, 0, 0, 2'b10);

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule